// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block owns the clock enable and the reset line of a single peripheral module. Software writes a 3-bit target state; the block moves the module into that state and reports which state is in effect, together with a busy flag while a move is still settling. Four states are purely static combinations of clock on/off and reset asserted/released. Two more are automatic: the module sits with its clock off and its reset released, and an incoming bus request switches the clock on by itself.

In the sleeping automatic state the clock is switched off again once the module has been idle for a short, parameterized time after its last acknowledged request. In the waking automatic state the first request switches the clock on and it stays on. In every state a bus request is acknowledged only after the clock has been running for a parameterized number of cycles and the reset is released. A request that reaches a module whose clock is off in a static state is refused with a one-cycle error pulse.

Top module: `clk_rst_state_ctrl`

## Requirements
- R1: After reset the status reads 0 (reset-held, clock off), `mod_rst` is 1, `clk_en` is 0 and `stat_busy` is 0.
- R2: A write with a valid code updates the target at the next clock edge; `stat_busy` is high from then until the state in effect has followed, which happens at the edge after that, when `stat_state` shows the new code.
- R3: Codes map to outputs as: 3 clock on and reset released; 2 clock off and reset released; 1 clock on and reset asserted; 0 clock off and reset asserted; 4 and 5 (automatic) clock off and reset released on entry.
- R4: Writes of codes 6 and 7 are ignored: state, outputs and busy are unchanged.
- R5: After `clk_en` rises, `ack` stays low for WAKE_LAT cycles; once the clock has run that long, a request is acknowledged in the same cycle it is presented.
- R6: In a static state with the clock off, a request is never acknowledged and `req_err` pulses high for exactly the first cycle of the request.
- R7: In state 4 or 5 with the clock off, a request raises `clk_en` at the next edge and is acknowledged WAKE_LAT cycles later; no `req_err` is raised.
- R8: In state 4 the clock goes off IDLE_CNT cycles after the last acknowledged cycle once the request is low; a request during that count is acknowledged at once and restarts the count.
- R9: In state 5, once woken, `clk_en` stays high for as long as the state is kept, whatever the requests do.
- R10: `stat_busy` is high while an automatic wake latency or an automatic return to sleep is in progress, and low once the module has settled.
- R11: While reset is asserted on the module (state 1), requests get neither `ack` nor `req_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Target state write strobe |
| cfg_state | input | 3 | Target state code |
| req | input | 1 | Bus read/write request to the module |
| ack | output | 1 | Request acknowledge |
| req_err | output | 1 | One-cycle pulse for a refused request |
| clk_en | output | 1 | Module clock enable |
| mod_rst | output | 1 | Module reset, active high |
| stat_state | output | 3 | State currently in effect |
| stat_busy | output | 1 | Transition or automatic wake/sleep in progress |

## Verification
The assertions watch, on every cycle, that an acknowledge only appears with the clock running and reset released, that no acknowledge shows in the cycle the clock enable rises, that the error flag never lasts two cycles, that a woken module in the stay-awake state keeps its clock, and that settled static states drive the matching output pair. Exact latencies cannot be seen by these properties: the count of cycles from clock enable to acknowledge, the idle count before sleep and its restart, and the ignoring of undefined codes from every starting state are measured only by the bench's sweeps and timed scenarios.

// File: rtl/clk_rst_state_ctrl.sv
module clk_rst_state_ctrl #(
  parameter int WAKE_LAT = 4,
  parameter int IDLE_CNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_state,
  input  logic       req,
  output logic       ack,
  output logic       req_err,
  output logic       clk_en,
  output logic       mod_rst,
  output logic [2:0] stat_state,
  output logic       stat_busy
);

  localparam int MAXC = (WAKE_LAT > IDLE_CNT) ? WAKE_LAT : IDLE_CNT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [2:0] S_RSTOFF = 3'd0;
  localparam logic [2:0] S_RSTON  = 3'd1;
  localparam logic [2:0] S_ON     = 3'd3;
  localparam logic [2:0] S_ASLEEP = 3'd4;
  localparam logic [2:0] S_AWAKE  = 3'd5;

  logic [2:0]    tgt, cur;
  logic          clk_q, rst_q, req_q, pend;
  logic          clk_nx, rst_nx, pend_nx;
  logic [CW-1:0] wcnt, icnt, icnt_nx;
  logic          cur_auto;

  assign cur_auto   = (cur == S_ASLEEP) || (cur == S_AWAKE);
  assign ack        = req && clk_q && !rst_q && (wcnt == '0);
  assign req_err    = req && !req_q && !clk_q && !cur_auto;
  assign clk_en     = clk_q;
  assign mod_rst    = rst_q;
  assign stat_state = cur;
  assign stat_busy  = (cur != tgt) || (clk_q && wcnt != '0) || pend;

  always_comb begin
    clk_nx  = clk_q;
    rst_nx  = rst_q;
    pend_nx = pend;
    icnt_nx = icnt;
    if (cur != tgt) begin
      clk_nx  = (tgt == S_RSTON) || (tgt == S_ON);
      rst_nx  = (tgt <= S_RSTON);
      pend_nx = 1'b0;
      icnt_nx = '0;
    end else if (cur_auto) begin
      if (!clk_q && req) clk_nx = 1'b1;
      if (cur == S_ASLEEP) begin
        if (ack) begin
          pend_nx = 1'b1;
          icnt_nx = CW'(IDLE_CNT);
        end else if (pend && !req) begin
          if (icnt <= CW'(1)) begin
            clk_nx  = 1'b0;
            pend_nx = 1'b0;
            icnt_nx = '0;
          end else begin
            icnt_nx = icnt - CW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt   <= S_RSTOFF;
      cur   <= S_RSTOFF;
      clk_q <= 1'b0;
      rst_q <= 1'b1;
      req_q <= 1'b0;
      pend  <= 1'b0;
      icnt  <= '0;
      wcnt  <= '0;
    end else begin
      if (cfg_we && cfg_state <= S_AWAKE) tgt <= cfg_state;
      cur   <= tgt;
      clk_q <= clk_nx;
      rst_q <= rst_nx;
      req_q <= req;
      pend  <= pend_nx;
      icnt  <= icnt_nx;
      if (!clk_q && clk_nx)  wcnt <= CW'(WAKE_LAT);
      else if (wcnt != '0)   wcnt <= wcnt - CW'(1);
    end
  end

  AST_ACK_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (clk_en && !mod_rst)); // R11
  AST_NO_ACK_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> !ack); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_err); // R6
  AST_ERR_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!clk_en && !ack)); // R6
  AST_AWAKE_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state == S_AWAKE && $past(stat_state) == S_AWAKE && $past(clk_en)) |-> clk_en); // R9
  AST_STATIC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_busy && stat_state <= S_ON) |->
      (clk_en == (stat_state == S_RSTON || stat_state == S_ON)) && (mod_rst == (stat_state <= S_RSTON))); // R3
  AST_AUTO_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_state >= S_ASLEEP) |-> !mod_rst); // R7
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state <= S_AWAKE); // R4

endmodule

// File: tb/test_clk_rst_state_ctrl.sv
`timescale 1ns/1ps
module test_clk_rst_state_ctrl;
  localparam int WL = 4;
  localparam int IC = 2;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, req = 1'b0;
  logic [2:0] cfg_state = 3'd0;
  logic ack, req_err, clk_en, mod_rst, stat_busy;
  logic [2:0] stat_state;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  clk_rst_state_ctrl #(.WAKE_LAT(WL), .IDLE_CNT(IC)) i_clk_rst_state_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_state(cfg_state), .req(req),
    .ack(ack), .req_err(req_err), .clk_en(clk_en), .mod_rst(mod_rst),
    .stat_state(stat_state), .stat_busy(stat_busy));

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(int code);
    cfg_we = 1'b1; cfg_state = 3'(code);
    step();
    cfg_we = 1'b0;
  endtask

  function automatic int xclk(int c); return (c == 1 || c == 3) ? 1 : 0; endfunction
  function automatic int xrst(int c); return (c <= 1) ? 1 : 0; endfunction

  task automatic settle(); repeat (WL + 2) step(); endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(500_000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n;
    @(negedge clk); #1;
    chk("R1 state", stat_state, 0); chk("R1 rst", mod_rst, 1);
    chk("R1 clk", clk_en, 0);       chk("R1 busy", stat_busy, 0);
    rst_n = 1'b1;
    step();
    chk("R1 state after release", stat_state, 0);

    // R2 R3 R4 sweep over all start states and all codes
    for (int a = 0; a <= 5; a++) begin
      for (int b = 0; b <= 7; b++) begin
        int e;
        wr(a); settle();
        e = (b <= 5) ? b : a;
        wr(b);
        chk($sformatf("R2 busy %0d->%0d", a, b), stat_busy, (e != a) ? 1 : 0);
        step();
        chk($sformatf("R2 state %0d->%0d", a, b), stat_state, e);
        settle();
        chk($sformatf("R4 state %0d->%0d", a, b), stat_state, e);
        chk($sformatf("R3 clk %0d", e), clk_en, xclk(e));
        chk($sformatf("R3 rst %0d", e), mod_rst, xrst(e));
        chk($sformatf("R10 busy settled %0d", e), stat_busy, 0);
      end
    end

    // R5 manual enable latency
    wr(0); settle();
    wr(3); step();
    chk("R5 clk on", clk_en, 1);
    req = 1'b1; #1;
    n = 0;
    while (!ack && n < 50) begin step(); n++; end
    chk("R5 latency", n, WL);
    req = 1'b0; step();
    req = 1'b1; #1;
    chk("R5 immediate ack", ack, 1);
    req = 1'b0; step();

    // R6 refused request with clock off
    wr(2); settle();
    req = 1'b1; #1;
    chk("R6 err first", req_err, 1); chk("R6 ack", ack, 0);
    step();
    chk("R6 err second", req_err, 0); chk("R6 ack later", ack, 0);
    req = 1'b0; step();

    // R11 reset held
    wr(1); settle();
    req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1; chk("R11 ack", ack, 0); chk("R11 err", req_err, 0); step();
    end
    req = 1'b0; step();

    // R7 R8 R10 auto sleep
    wr(4); settle();
    chk("R7 clk off", clk_en, 0); chk("R7 rst", mod_rst, 0);
    req = 1'b1; #1;
    chk("R7 no err", req_err, 0);
    n = 0;
    while (!ack && n < 50) begin
      step(); n++;
      if (n == 1) begin chk("R7 clk up", clk_en, 1); chk("R10 busy wake", stat_busy, 1); end
    end
    chk("R7 latency", n, WL + 1);
    step(); req = 1'b0; #1;
    chk("R10 busy sleep", stat_busy, 1);
    n = 0;
    while (clk_en && n < 50) begin step(); n++; end
    chk("R8 idle count", n, IC);
    chk("R10 busy after sleep", stat_busy, 0);
    // restart of idle count
    req = 1'b1;
    while (!ack) step();
    step(); req = 1'b0;
    step();
    req = 1'b1; #1;
    chk("R8 ack during count", ack, 1);
    step(); req = 1'b0; #1;
    n = 0;
    while (clk_en && n < 50) begin step(); n++; end
    chk("R8 restarted count", n, IC);

    // R9 auto wake
    wr(5); settle();
    chk("R9 clk off on entry", clk_en, 0);
    req = 1'b1; #1;
    n = 0;
    while (!ack && n < 50) begin step(); n++; end
    chk("R9 latency", n, WL + 1);
    step(); req = 1'b0;
    repeat (20) step();
    chk("R9 stays on", clk_en, 1);
    chk("R9 state", stat_state, 5);
    chk("R10 busy awake", stat_busy, 0);
    req = 1'b1; #1;
    chk("R9 ack awake", ack, 1);
    req = 1'b0; step();

    finish_run();
  end
endmodule